// File: doc/BRIEF.md
# Edge-Armed Asynchronous Event Counter

This block is a 16-bit up-counter whose count events are the rising edges of a slow clock that has no phase relation to the host clock. The count source is either an external oscillator input, brought into the host domain through a synchronizer, or an internal square wave made by dividing the host clock. The host loads the counter one byte at a time. A high-byte write is held in a buffer. A low-byte write then loads both bytes into the counter in a single cycle, so a running count is never seen half old and half new.

After any load, and after the counter is enabled, an arming latch blocks increments until the selected source shows a falling edge. A rising edge that arrives before that falling edge is ignored. Because the internal source always starts low when it is selected, switching from an external source that is held high to the internal source creates the falling edge that arms the counter. A sticky flag records each wrap from all ones to zero and stays set until the host clears it.

Top module: `edge_armed_counter`

## Requirements
- R1: While reset is high, count reads 0x0000 and the wrap flag reads 0 on the cycle after each clock edge.
- R2: A high-byte write only updates a holding byte and leaves count unchanged. A low-byte write sets count to {holding byte, written byte} on the next cycle. The holding byte keeps its value across later low-byte writes.
- R3: While enabled and armed, count increases by exactly one for each rising edge of the selected source. The source is the external input when the source-select pin is 1 and the internal source when it is 0. The external input passes through a two-stage synchronizer.
- R4: After a low-byte write or a 0-to-1 change of enable, rising edges are ignored until a falling edge is seen. A load made while the source is high therefore counts every later rising edge. A load made while the source is low loses the first rising edge.
- R5: While enable is 0, source edges neither change count nor arm the counter.
- R6: An increment from 0xFFFF gives 0x0000 and sets the wrap flag. The flag then stays at 1 until a clear pulse, and a wrap in the same cycle as a clear leaves it set.
- R7: The internal source is held low while it is not selected. Once selected, it first toggles DIV host cycles later and then every DIV cycles (default DIV = 4). Selecting it while the external input is high therefore produces a falling edge that arms the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External asynchronous count source |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | Source select: 1 external, 0 internal divider |
| wr_hi | input | 1 | Write strobe for the high holding byte |
| wr_lo | input | 1 | Write strobe for the low byte, loads full count |
| wr_data | input | 8 | Write data byte |
| ovf_clr | input | 1 | Clear pulse for the wrap flag |
| count | output | 16 | Current count |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The bench loads the counter in the high phase and in the low phase of the external clock and then counts a known number of rising edges. A design that leaves out the arming latch scores one count too many after a low-phase load, and a design that arms on the wrong edge scores one too few after a high-phase load. Loads just below 0xFFFF check that the result wraps exactly to zero and that the flag is set only when a wrap really happens. A design that increments on any level or forgets the flag would miss these values. Further checks cover a high-byte write that must leave the count unchanged, edges while disabled, and the arming falling edge created by a switch to the internal source.

// File: rtl/acnt_pkg.sv
package acnt_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic load;
        logic en_rise;
    } disarm_t;

    function automatic edge_t find_edges(input logic now_lvl, input logic prev_lvl);
        edge_t e;
        e.rise = now_lvl & ~prev_lvl;
        e.fall = ~now_lvl & prev_lvl;
        return e;
    endfunction

    function automatic logic any_disarm(input disarm_t d);
        return d.load | d.en_rise;
    endfunction

endpackage

// File: rtl/acnt_sync.sv
module acnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/acnt_intsrc.sv
module acnt_intsrc #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic lvl
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            div_q <= '0;
            lvl_q <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign lvl = lvl_q;

    // R7: parked low while another source is selected
    a_r7_parked_low: assert property (@(posedge clk) disable iff (rst)
        !active |=> !lvl);
endmodule

// File: rtl/acnt_arm.sv
module acnt_arm
    import acnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e sel,
    input  logic     ext_lvl,
    input  logic     int_lvl,
    input  logic     run_en,
    input  logic     load,
    output logic     step
);
    logic    lvl_now;
    logic    lvl_prev;
    logic    en_q;
    logic    armed;
    edge_t   edges;
    disarm_t why;

    assign lvl_now     = (sel == SRC_EXT) ? ext_lvl : int_lvl;
    assign edges       = find_edges(lvl_now, lvl_prev);
    assign why.load    = load;
    assign why.en_rise = run_en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            en_q     <= 1'b0;
            armed    <= 1'b0;
        end else begin
            lvl_prev <= lvl_now;
            en_q     <= run_en;
            if (any_disarm(why))
                armed <= 1'b0;
            else if (run_en && edges.fall)
                armed <= 1'b1;
        end
    end

    assign step = run_en & armed & edges.rise & ~load;

    // R4: arming only follows an observed falling edge
    a_r4_arm_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(edges.fall));
    // R4: a load always leaves the counter disarmed
    a_r4_load_disarms: assert property (@(posedge clk) disable iff (rst)
        load |=> !armed);
    // R5: no arming while disabled
    a_r5_no_arm_idle: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !armed) |=> !armed);
endmodule

// File: rtl/acnt_core.sv
module acnt_core #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              step,
    input  logic              ovf_clr,
    output logic              load,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    logic [BYTE_W-1:0] hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              at_top;

    assign load   = wr_lo;
    assign at_top = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_hi)
                hold_q <= wr_data;
            if (wr_lo)
                cnt_q <= {hold_q, wr_data};
            else if (step)
                cnt_q <= cnt_q + CNT_W'(1);
            if (step && at_top)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    // R2: a high-byte write alone leaves the count
    a_r2_hi_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo && !step) |=> count == $past(count));
    // R3: the count moves by at most one without a load
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
    // R6: wrap yields zero and sets the flag
    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_lo && count == {CNT_W{1'b1}}) |=> (ovf && count == '0));
    // R6: flag is sticky until cleared
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/edge_armed_counter.sv
module edge_armed_counter
    import acnt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_clk,
    input  logic                run_en,
    input  logic                src_ext,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                ovf_clr,
    output logic [2*BYTE_W-1:0] count,
    output logic                ovf
);
    localparam int CNT_W = 2 * BYTE_W;

    src_sel_e sel;
    logic     ext_lvl;
    logic     int_lvl;
    logic     load;
    logic     step;

    assign sel = src_sel_e'(src_ext);

    acnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_clk),
        .q   (ext_lvl)
    );

    acnt_intsrc #(.DIV(DIV)) u_intsrc (
        .clk    (clk),
        .rst    (rst),
        .active (sel == SRC_INT),
        .lvl    (int_lvl)
    );

    acnt_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .ext_lvl (ext_lvl),
        .int_lvl (int_lvl),
        .run_en  (run_en),
        .load    (load),
        .step    (step)
    );

    acnt_core #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .step    (step),
        .ovf_clr (ovf_clr),
        .load    (load),
        .count   (count),
        .ovf     (ovf)
    );

    // R1: reset clears count and flag
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf));
    // R5: disabled counter only changes through a load
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_lo) |=> count == $past(count));
endmodule

// File: tb/edge_armed_counter_tb.sv
module edge_armed_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int DIV        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk = 1'b0;
    logic        run_en = 1'b1;
    logic        src_ext = 1'b1;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        ovf;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_armed_counter u_dut (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .run_en(run_en),
        .src_ext(src_ext), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write16(input logic [15:0] v);
        wr_hi = 1'b1; wr_data = v[15:8]; tick();
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0]; tick();
        wr_lo = 1'b0;
    endtask

    // act: 0 nothing, 1 load v, 2 enable
    task automatic toggle(input int act, input logic [15:0] v);
        ext_clk = ~ext_clk;
        repeat (4) tick();
        if (act == 1) write16(v);
        else begin
            if (act == 2) run_en = 1'b1;
            repeat (2) tick();
        end
        repeat (HALF - 6) tick();
    endtask

    // p: external level at the action; r: rising edges afterwards
    task automatic run_case(input int act, input logic [15:0] v, input bit p, input int r);
        int rises = 0;
        if (ext_clk == p) toggle(0, 16'h0);
        toggle(act, v);
        while (rises < r) begin
            toggle(0, 16'h0);
            if (ext_clk) rises++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] base;
        logic [16:0] sum;
        @(negedge clk);
        repeat (3) tick();
        check("R1 count in reset", count, 0);
        check("R1 flag in reset", ovf, 0);
        rst = 1'b0;
        tick();

        // R3/R4: loads in both phases, several rising-edge counts
        foreach (base[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [15:0] vals [4] = '{16'h0000, 16'h1234, 16'h7FFE, 16'hA5C3};
            for (int p = 0; p < 2; p++) begin
                for (int r = 1; r <= 3; r++) begin
                    run_case(1, vals[k], p[0], r);
                    check(p ? "R3 count after high-phase load" : "R4 count after low-phase load",
                          count, vals[k] + 16'(p ? r : r - 1));
                end
            end
        end

        // R6: wrap sweep near the top
        for (int k = 0; k < 4; k++) begin
            for (int r = 1; r <= 4; r++) begin
                ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
                base = 16'hFFFC + 16'(k);
                sum  = {1'b0, base} + 17'(r);
                run_case(1, base, 1'b1, r);
                check("R6 wrapped count", count, sum[15:0]);
                check("R6 flag on wrap", ovf, sum[16]);
            end
        end
        toggle(0, 16'h0); toggle(0, 16'h0);
        check("R6 flag sticky", ovf, 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        check("R6 flag cleared", ovf, 0);

        // R5: disabled counter ignores edges
        base = count;
        run_en = 1'b0;
        for (int i = 0; i < 6; i++) toggle(0, 16'h0);
        check("R5 disabled holds count", count, base);
        run_case(2, 16'h0, 1'b1, 2);
        check("R4 enable in high phase", count, base + 16'd2);
        run_en = 1'b0;
        base = count;
        run_case(2, 16'h0, 1'b0, 2);
        check("R4 enable in low phase", count, base + 16'd1);

        // R2: byte buffering, clock quiet
        base = count;
        wr_hi = 1'b1; wr_data = 8'hAB; tick(); wr_hi = 1'b0;
        check("R2 high write keeps count", count, base);
        wr_lo = 1'b1; wr_data = 8'h01; tick(); wr_lo = 1'b0;
        check("R2 low write loads", count, 16'hAB01);
        wr_lo = 1'b1; wr_data = 8'h02; tick(); wr_lo = 1'b0;
        check("R2 holding byte kept", count, 16'hAB02);

        // R7: switch to internal source while external is high
        if (!ext_clk) toggle(0, 16'h0);
        write16(16'h4000);
        src_ext = 1'b0;
        repeat (2 * DIV) tick();
        check("R7 first internal rise counted", count, 16'h4001);
        repeat (2 * DIV) tick();
        check("R7 second internal rise counted", count, 16'h4002);
        src_ext = 1'b1;
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule